// File: doc/BRIEF.md
# CPU Reset and Strap Capture Sequencer

This controller sits on the platform side of a processor socket and produces the processor reset from a board power-good level and the free-running bus clock. Once power-good is seen high, reset is held active for a whole number of milliseconds. The hold time is counted in bus clocks and comes from a small hold-time input that is latched when the hold starts. On the clock edge where reset is released, the controller samples a vector of hardware configuration straps. That value is then held unchanged until the next release.

While the processor runs, the controller watches a thermal-trip input. A trip moves it into a latched thermal-off state and raises a request to cut the supply. The trip input carries no meaning while reset is active, so it is ignored outside the running state. The thermal-off state is left only by a real loss of power-good. A dip in power-good shorter than a minimum number of clocks does not count as a loss. A two-bit status output reports the sequencer state.

Top module: `pwr_rst_sequencer`

## Requirements
- R1: While `sysRstN` is low, and afterwards until power-good is seen high, the outputs are as follows. `seqState` is 0 (power-down), `cpuResetN` is 0, `supplyOff` is 0 and `cfgOut` is all zeros. The state codes are: 0 power-down, 1 reset-hold, 2 running, 3 thermal-off.
- R2: In power-down, a clock edge that samples `pwrGood` high moves `seqState` to 1 at that edge, and `cpuResetN` stays 0.
- R3: `cpuResetN` rises exactly CLK_PER_MS*N clock edges after the edge that entered reset-hold. N is the hold count latched from `holdMs` at that entry edge. For every earlier edge the state reads 1.
- R4: The hold count is derived from `holdMs` at the entry edge. A value of 0 selects DEF_MS (2). A value above MAX_MS (10) selects MAX_MS. Any other value is used as given.
- R5: `cfgOut` takes the value of `strapIn` sampled at the edge where `cpuResetN` rises, and does not change at any other edge. Strap changes during reset-hold, while running, or through a later hold do not reach `cfgOut` before the next release.
- R6: A run of fewer than PG_MIN_LOW consecutive low samples of `pwrGood` has no effect on the state.
- R7: When `pwrGood` is sampled low on PG_MIN_LOW consecutive edges, the loss is confirmed. At the following edge the state becomes power-down and `cpuResetN` is 0. This applies from reset-hold, running and thermal-off.
- R8: `thermTrip` has no effect in power-down or reset-hold.
- R9: In running, an edge that samples `thermTrip` high moves the state to 3. From that edge `supplyOff` is 1 and `cpuResetN` is 0.
- R10: Thermal-off persists regardless of `thermTrip` and of power-good staying high. Only a confirmed power-good loss (R7) leaves it, and it leaves to power-down, where `supplyOff` returns to 0.
- R11: When a confirmed loss and a sampled trip fall on the same edge in running, the loss wins and the state becomes power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the controller itself |
| pwrGood | input | 1 | Board power-good level |
| holdMs | input | MS_W | Requested reset hold in milliseconds (0 selects the default) |
| strapIn | input | CFG_W | Hardware configuration straps |
| thermTrip | input | 1 | Thermal-trip indication from the processor, active high |
| cpuResetN | output | 1 | Processor reset, active low |
| cfgOut | output | CFG_W | Straps frozen at the last reset release |
| supplyOff | output | 1 | Request to remove processor supply |
| seqState | output | 2 | Sequencer state code |

## Verification
The hardest case to reach from the ports is the edge where a confirmed power-good loss and a thermal trip arrive together in the running state. The bench holds `pwrGood` low for exactly PG_MIN_LOW edges and raises `thermTrip` only in the cycle just before the deciding edge, so both conditions meet there. A second hard case is telling a glitch apart from a loss. One low run stops a single sample short of the threshold and another meets it exactly. A third covers the hold-count mapping: values below, inside and above the allowed range are each followed to the release edge, and the strap vector is changed mid-hold so that the release-edge sample is the only value that can appear.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

  typedef enum logic [1:0] {
    ST_PWR_DOWN  = 2'd0,
    ST_RST_HOLD  = 2'd1,
    ST_RUN       = 2'd2,
    ST_THERM_OFF = 2'd3
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdLoad;   // latch hold target, clear hold counter
    logic holdRun;    // advance hold counter
    logic capture;    // freeze straps into cfg register
  } seq_strobe_t;

endpackage

// File: rtl/prs_datapath.sv
module prs_datapath
  import pwr_rst_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int CLK_PER_MS = 100000,
  parameter int MS_W       = 4,
  parameter int DEF_MS     = 2,
  parameter int MAX_MS     = 10,
  parameter int PG_MIN_LOW = 10
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             pwrGood,
  input  logic [MS_W-1:0]  holdMs,
  input  logic [CFG_W-1:0] strapIn,
  input  seq_strobe_t      stb,
  output logic             pgDrop,
  output logic             holdDone,
  output logic [CFG_W-1:0] cfgOut
);

  localparam int CNT_W = $clog2(CLK_PER_MS * MAX_MS + 1);
  localparam int LOW_W = $clog2(PG_MIN_LOW + 1);
  localparam logic [CNT_W-1:0] PER_MS  = CNT_W'(CLK_PER_MS);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(PG_MIN_LOW);

  logic [MS_W-1:0]  msEff;
  logic [CNT_W-1:0] msExt;
  logic [CNT_W-1:0] targetNext;
  logic [CNT_W-1:0] holdTarget;
  logic [CNT_W-1:0] holdCnt;
  logic [LOW_W-1:0] lowCnt;
  logic [CFG_W-1:0] cfgReg;

  // hold count selection: zero picks default, large values saturate
  always_comb begin
    if (holdMs == '0)
      msEff = MS_W'(DEF_MS);
    else if (holdMs > MS_W'(MAX_MS))
      msEff = MS_W'(MAX_MS);
    else
      msEff = holdMs;
    msExt      = CNT_W'(msEff);
    targetNext = PER_MS * msExt;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      holdTarget <= '0;
      holdCnt    <= '0;
    end else if (stb.holdLoad) begin
      holdTarget <= targetNext;
      holdCnt    <= '0;
    end else if (stb.holdRun) begin
      holdCnt <= holdCnt + CNT_W'(1);
    end
  end

  assign holdDone = (holdCnt == holdTarget - CNT_W'(1));

  // power-good low-run filter: a loss is confirmed after PG_MIN_LOW low samples
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)
      lowCnt <= '0;
    else if (pwrGood)
      lowCnt <= '0;
    else if (lowCnt != LOW_MAX)
      lowCnt <= lowCnt + LOW_W'(1);
  end

  assign pgDrop = (lowCnt == LOW_MAX);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)
      cfgReg <= '0;
    else if (stb.capture)
      cfgReg <= strapIn;
  end

  assign cfgOut = cfgReg;

endmodule

// File: rtl/prs_control.sv
module prs_control
  import pwr_rst_pkg::*;
(
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        pwrGood,
  input  logic        thermTrip,
  input  logic        pgDrop,
  input  logic        holdDone,
  output seq_state_e  state,
  output seq_strobe_t stb
);

  seq_state_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PWR_DOWN:  if (pwrGood) stateNext = ST_RST_HOLD;
      ST_RST_HOLD: begin
        if (pgDrop)        stateNext = ST_PWR_DOWN;
        else if (holdDone) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (pgDrop)         stateNext = ST_PWR_DOWN;
        else if (thermTrip) stateNext = ST_THERM_OFF;
      end
      ST_THERM_OFF: if (pgDrop) stateNext = ST_PWR_DOWN;
      default:      stateNext = ST_PWR_DOWN;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.holdLoad = (state == ST_PWR_DOWN) && pwrGood;
    stb.holdRun  = (state == ST_RST_HOLD);
    stb.capture  = (state == ST_RST_HOLD) && holdDone && !pgDrop;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) state <= ST_PWR_DOWN;
    else          state <= stateNext;
  end

endmodule

// File: rtl/pwr_rst_sequencer.sv
module pwr_rst_sequencer
  import pwr_rst_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int CLK_PER_MS = 100000,
  parameter int MS_W       = 4,
  parameter int DEF_MS     = 2,
  parameter int MAX_MS     = 10,
  parameter int PG_MIN_LOW = 10
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             pwrGood,
  input  logic [MS_W-1:0]  holdMs,
  input  logic [CFG_W-1:0] strapIn,
  input  logic             thermTrip,
  output logic             cpuResetN,
  output logic [CFG_W-1:0] cfgOut,
  output logic             supplyOff,
  output logic [1:0]       seqState
);

  seq_state_e  state;
  seq_strobe_t stb;
  logic        pgDrop;
  logic        holdDone;

  prs_control u_ctrl (
    .clk      (clk),
    .sysRstN  (sysRstN),
    .pwrGood  (pwrGood),
    .thermTrip(thermTrip),
    .pgDrop   (pgDrop),
    .holdDone (holdDone),
    .state    (state),
    .stb      (stb)
  );

  prs_datapath #(
    .CFG_W     (CFG_W),
    .CLK_PER_MS(CLK_PER_MS),
    .MS_W      (MS_W),
    .DEF_MS    (DEF_MS),
    .MAX_MS    (MAX_MS),
    .PG_MIN_LOW(PG_MIN_LOW)
  ) u_dp (
    .clk     (clk),
    .sysRstN (sysRstN),
    .pwrGood (pwrGood),
    .holdMs  (holdMs),
    .strapIn (strapIn),
    .stb     (stb),
    .pgDrop  (pgDrop),
    .holdDone(holdDone),
    .cfgOut  (cfgOut)
  );

  assign cpuResetN = (state == ST_RUN);
  assign supplyOff = (state == ST_THERM_OFF);
  assign seqState  = state;

endmodule

// File: rtl/pwr_rst_sequencer_chk.sv
module pwr_rst_sequencer_chk
  import pwr_rst_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int CLK_PER_MS = 100000
) (
  input logic             clk,
  input logic             sysRstN,
  input logic             thermTrip,
  input logic [CFG_W-1:0] strapIn,
  input logic             cpuResetN,
  input logic [CFG_W-1:0] cfgOut,
  input logic             supplyOff,
  input logic [1:0]       seqState
);

  int unsigned holdCycles;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)
      holdCycles <= 0;
    else if (seqState == ST_RST_HOLD) begin
      if (holdCycles != 32'hFFFF_FFFF) holdCycles <= holdCycles + 1;
    end else
      holdCycles <= 0;
  end

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(cpuResetN) |-> holdCycles >= CLK_PER_MS); // R3

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(cpuResetN) |-> cfgOut == $past(strapIn)); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!sysRstN)
    !$rose(cpuResetN) |-> $stable(cfgOut)); // R5

  AST_TRIP_IGNORED: assert property (@(posedge clk) disable iff (!sysRstN)
    seqState == ST_RST_HOLD |=> seqState != ST_THERM_OFF); // R8

  AST_TRIP_RESPONSE: assert property (@(posedge clk) disable iff (!sysRstN)
    (seqState == ST_RUN && thermTrip) |=> (supplyOff || seqState == ST_PWR_DOWN)); // R9

  AST_OFF_LATCHED: assert property (@(posedge clk) disable iff (!sysRstN)
    seqState == ST_THERM_OFF |=> (seqState == ST_THERM_OFF || seqState == ST_PWR_DOWN)); // R10

  AST_OFF_NO_RUN: assert property (@(posedge clk) disable iff (!sysRstN)
    supplyOff |-> !cpuResetN); // R9

endmodule

bind pwr_rst_sequencer pwr_rst_sequencer_chk #(
  .CFG_W     (CFG_W),
  .CLK_PER_MS(CLK_PER_MS)
) chk (.*);

// File: tb/pwr_rst_sequencer_test.sv
module pwr_rst_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W      = 8;
  localparam int MS_W       = 4;
  localparam int CPM        = 10;
  localparam int MIN_LOW    = 4;

  logic             clk = 1'b0;
  logic             sysRstN = 1'b0;
  logic             pwrGood = 1'b0;
  logic [MS_W-1:0]  holdMs = '0;
  logic [CFG_W-1:0] strapIn = 8'hA5;
  logic             thermTrip = 1'b0;
  logic             cpuResetN;
  logic [CFG_W-1:0] cfgOut;
  logic             supplyOff;
  logic [1:0]       seqState;

  pwr_rst_sequencer #(
    .CFG_W(CFG_W), .CLK_PER_MS(CPM), .MS_W(MS_W),
    .DEF_MS(2), .MAX_MS(10), .PG_MIN_LOW(MIN_LOW)
  ) uut (
    .clk(clk), .sysRstN(sysRstN), .pwrGood(pwrGood), .holdMs(holdMs),
    .strapIn(strapIn), .thermTrip(thermTrip), .cpuResetN(cpuResetN),
    .cfgOut(cfgOut), .supplyOff(supplyOff), .seqState(seqState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int               cyc;
    string            req;
    logic [1:0]       st;
    logic             rn;
    logic             so;
    logic [CFG_W-1:0] cfg;
  } exp_t;

  exp_t expQ[$];
  int   cyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: queue an expectation k posedges from now
  task automatic expect_at(input int k, input string req, input logic [1:0] st,
                           input logic rn, input logic so, input logic [CFG_W-1:0] cfg);
    exp_t e;
    e.cyc = cyc + k; e.req = req; e.st = st; e.rn = rn; e.so = so; e.cfg = cfg;
    expQ.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: compare at the negedge where the item is due
  always @(negedge clk) begin
    exp_t e;
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      e = expQ.pop_front();
      nChecks++;
      if (e.cyc != cyc) begin
        nFails++;
        $display("FAIL %s: check for cycle %0d missed (now %0d), expected state %0d",
                 e.req, e.cyc, cyc, e.st);
      end else if (seqState !== e.st || cpuResetN !== e.rn ||
                   supplyOff !== e.so || cfgOut !== e.cfg) begin
        nFails++;
        $display("FAIL %s @%0d: actual st=%0d rstN=%0b off=%0b cfg=%h, expected st=%0d rstN=%0b off=%0b cfg=%h",
                 e.req, cyc, seqState, cpuResetN, supplyOff, cfgOut,
                 e.st, e.rn, e.so, e.cfg);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      nFails += expQ.size();
      nChecks += expQ.size();
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not end, actual timeout, expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    sysRstN = 1'b1;
    // R1: idle outputs after controller reset, power-good still low
    expect_at(1, "R1", 2'd0, 1'b0, 1'b0, 8'h00);
    tick(2);

    // R2/R3/R4 default hold (holdMs=0 -> 2 ms = 20 clocks), R5 mid-hold strap change
    pwrGood = 1'b1;
    expect_at(1,  "R2", 2'd1, 1'b0, 1'b0, 8'h00);
    expect_at(20, "R3", 2'd1, 1'b0, 1'b0, 8'h00);
    tick(10);
    strapIn = 8'h5A;
    expect_at(11, "R4", 2'd2, 1'b1, 1'b0, 8'h5A);
    tick(11);
    strapIn = 8'hFF;
    expect_at(3, "R5", 2'd2, 1'b1, 1'b0, 8'h5A);
    tick(3);

    // R6: low run one short of the threshold is ignored
    pwrGood = 1'b0;
    tick(MIN_LOW - 1);
    pwrGood = 1'b1;
    expect_at(2, "R6", 2'd2, 1'b1, 1'b0, 8'h5A);
    tick(2);

    // R9: trip while running, R10: stays off with trip gone and power-good high
    thermTrip = 1'b1;
    expect_at(1, "R9", 2'd3, 1'b0, 1'b1, 8'h5A);
    tick(1);
    thermTrip = 1'b0;
    expect_at(5, "R10", 2'd3, 1'b0, 1'b1, 8'h5A);
    tick(5);

    // R7/R10: confirmed loss exits thermal-off
    pwrGood = 1'b0;
    expect_at(MIN_LOW,     "R10", 2'd3, 1'b0, 1'b1, 8'h5A);
    expect_at(MIN_LOW + 1, "R7",  2'd0, 1'b0, 1'b0, 8'h5A);
    tick(MIN_LOW + 1);

    // R8: trip in power-down has no effect
    thermTrip = 1'b1;
    expect_at(3, "R8", 2'd0, 1'b0, 1'b0, 8'h5A);
    tick(3);

    // R8 during reset-hold, R4 clamp (15 -> 10 ms = 100 clocks)
    holdMs  = 4'd15;
    strapIn = 8'hC3;
    pwrGood = 1'b1;
    expect_at(1,  "R2", 2'd1, 1'b0, 1'b0, 8'h5A);
    expect_at(60, "R8", 2'd1, 1'b0, 1'b0, 8'h5A);
    tick(90);
    thermTrip = 1'b0;
    expect_at(10, "R4", 2'd1, 1'b0, 1'b0, 8'h5A);
    expect_at(11, "R4", 2'd2, 1'b1, 1'b0, 8'hC3);
    tick(11);

    // R11: confirmed loss and trip on the same edge
    pwrGood = 1'b0;
    tick(MIN_LOW);
    thermTrip = 1'b1;
    expect_at(1, "R11", 2'd0, 1'b0, 1'b0, 8'hC3);
    tick(1);
    thermTrip = 1'b0;

    // R7 from reset-hold, with holdMs=1 (10 clocks)
    holdMs  = 4'd1;
    pwrGood = 1'b1;
    expect_at(1, "R2", 2'd1, 1'b0, 1'b0, 8'hC3);
    tick(5);
    pwrGood = 1'b0;
    expect_at(MIN_LOW,     "R7", 2'd1, 1'b0, 1'b0, 8'hC3);
    expect_at(MIN_LOW + 1, "R7", 2'd0, 1'b0, 1'b0, 8'hC3);
    tick(MIN_LOW + 1);

    // R3/R4 in-range hold of 1 ms, new straps captured
    strapIn = 8'h77;
    pwrGood = 1'b1;
    expect_at(CPM,     "R3", 2'd1, 1'b0, 1'b0, 8'hC3);
    expect_at(CPM + 1, "R4", 2'd2, 1'b1, 1'b0, 8'h77);
    tick(CPM + 1);
    tick(3);
    finish_run();
  end

endmodule